// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a full-duplex serial master. When it accepts a start pulse, it loads a parallel word and shifts it out on `mosi` one bit per serial clock period. In the same periods it shifts `miso` into a separate receive register. It generates `sclk` from the system clock and drives one slave-select line. When the last bit has moved, it raises a one-cycle `done` pulse and presents the received word right-aligned on `rxWord`.

Static configuration inputs set the following. Each input should stay stable while a transfer runs.
- Word length: 4 to 32 bits, coded as length minus one.
- Bit order.
- Clock idle level and clock phase.
- Select polarity, and whether select is timed by the controller or taken from a firmware-written bit.
- Lead and lag delays around the select.
- The serial clock divider.
- Transmit enable and receive enable, set separately.
- Internal loopback.

Two running counters report how many bytes have moved on each path.

Top module: `spi_word_master`

## Requirements
- R1: Each accepted transfer ends with `done` high for exactly one cycle. `rxWord` then holds the W received bits in bits W-1..0, and all higher bits are zero.
- R2: The word length W is `cfgWidthM1`+1 for field values 3 to 31. Field values 0, 1 and 2 act as W=4. Transmit bits above W-1 are ignored.
- R3: `cfgLsbFirst`=0 sends and stores bit W-1 first. `cfgLsbFirst`=1 sends and stores bit 0 first. The setting applies to both paths.
- R4: `sclk` rests at `cfgCpol` whenever no transfer is active. Each word gives exactly 2·W `sclk` transitions.
- R5: With `cfgCpha`=0, the first bit is on `mosi` before the first edge, `miso` is sampled on leading edges, and `mosi` changes on trailing edges. With `cfgCpha`=1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R6: `cfgSelActHigh`=1 makes `ssel` active high. `cfgSelActHigh`=0 makes it active low.
- R7: In automatic mode, `ssel` goes active in the cycle after the start is accepted. The first `sclk` edge follows (`cfgLead`+1)·H cycles later. `ssel` goes inactive `cfgLag`·H cycles after the last edge, in the same cycle that `done` is seen.
- R8: With `cfgSelManual`=1, `ssel` follows `cfgSelFwBit` (1 = active) whatever the transfer state is.
- R9: While `cfgTxEn`=0, `mosi` stays 0 and the transmit byte count does not change.
- R10: While `cfgRxEn`=0, `rxWord` keeps its value and the receive byte count does not change.
- R11: With `cfgLoopback`=1, the receive path takes the `mosi` value in place of `miso`.
- R12: Each completed word adds ceil(W/8) to `txByteCount` if transmit is enabled, and to `rxByteCount` if receive is enabled. Both counts wrap.
- R13: A start pulse is ignored while `busy` is high. `busy` rises only in the cycle after an accepted start, and it falls when `done` is seen.
- R14: One `sclk` half period lasts H = `cfgHalfDiv` system cycles. A value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWidthM1 | input | 5 | Word length minus one |
| cfgLsbFirst | input | 1 | 1: least significant bit first |
| cfgCpol | input | 1 | Idle level of `sclk` |
| cfgCpha | input | 1 | Clock phase selection |
| cfgSelActHigh | input | 1 | 1: select is active high |
| cfgSelManual | input | 1 | 1: select taken from `cfgSelFwBit` |
| cfgSelFwBit | input | 1 | Firmware select value (1 = active) |
| cfgTxEn | input | 1 | Transmit path enable |
| cfgRxEn | input | 1 | Receive path enable |
| cfgLoopback | input | 1 | Route `mosi` into the receive path |
| cfgLead | input | 4 | Extra half periods before the first edge |
| cfgLag | input | 4 | Half periods of select after the last edge |
| cfgHalfDiv | input | 8 | System cycles per `sclk` half period |
| start | input | 1 | Start pulse for one word |
| txWord | input | 32 | Word to send, sampled at accept |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| rxWord | output | 32 | Last received word, right-aligned |
| txByteCount | output | 16 | Running count of transmitted bytes |
| rxByteCount | output | 16 | Running count of received bytes |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel | output | 1 | Slave select |

## Verification
A behavioural slave returns a known word and captures what arrives on `mosi`. The bench runs it in all four polarity and phase combinations, in both bit orders, and at lengths of 4, 8, 13 and 32 bits, plus a clamped length field. These runs separate a wrong sampling edge, a reversed order and a bad width mask. Loopback runs are made with a conflicting slave word, which shows whether `miso` is really bypassed. Runs with a path disabled show whether `mosi` stays quiet, whether `rxWord` is left unchanged, and whether the byte counts respond to the enables. Timing runs measure the lead, lag and divider in cycles, including the divider value 0. A second start pulse during a transfer shows whether it is ignored.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

  // control-to-datapath strobes, all single-cycle
  typedef struct packed {
    logic load;    // accept a new word
    logic launch;  // put next transmit bit on the line
    logic sample;  // capture one receive bit
    logic finish;  // word complete
  } spi_stb_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_LAG   = 2'd3
  } spi_state_t;

endpackage

// File: rtl/spi_word_ctrl.sv
module spi_word_ctrl
  import spi_word_pkg::*;
#(
  parameter int WSEL_W = 5,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 4,
  localparam int EDGE_W = WSEL_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cfgCpha,
  input  logic [DLY_W-1:0]  cfgLead,
  input  logic [DLY_W-1:0]  cfgLag,
  input  logic [DIV_W-1:0]  cfgHalfDiv,
  input  logic [WSEL_W-1:0] effWM1,
  output spi_stb_t          stb,
  output logic              busy,
  output logic              done,
  output logic              sclkLvl
);

  spi_state_t        state;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  halfLim;
  logic [DLY_W-1:0]  phaseCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic              tick;
  logic              lastEdge;
  logic              inShift;

  always_comb begin
    halfLim  = (cfgHalfDiv == '0) ? '0 : cfgHalfDiv - 1'b1;
    tick     = (state != ST_IDLE) && (divCnt == halfLim);
    lastEdge = (edgeCnt == {effWM1, 1'b1});
    inShift  = (state == ST_SHIFT) && tick;
    stb        = '0;
    stb.load   = (state == ST_IDLE) && start;
    // even edge index = leading edge, odd = trailing edge
    stb.launch = (stb.load && !cfgCpha) ||
                 (inShift && (cfgCpha ? !edgeCnt[0] : (edgeCnt[0] && !lastEdge)));
    stb.sample = inShift && (cfgCpha ? edgeCnt[0] : !edgeCnt[0]);
    stb.finish = tick && (((state == ST_SHIFT) && lastEdge && (cfgLag == '0)) ||
                          ((state == ST_LAG) && (phaseCnt == cfgLag - 1'b1)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      phaseCnt <= '0;
      edgeCnt  <= '0;
      sclkLvl  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= stb.finish;
      if (state == ST_IDLE) begin
        if (start) begin
          divCnt   <= '0;
          phaseCnt <= '0;
          edgeCnt  <= '0;
          state    <= (cfgLead == '0) ? ST_SHIFT : ST_LEAD;
        end
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          case (state)
            ST_LEAD: begin
              if (phaseCnt == cfgLead - 1'b1) begin
                phaseCnt <= '0;
                state    <= ST_SHIFT;
              end else begin
                phaseCnt <= phaseCnt + 1'b1;
              end
            end
            ST_SHIFT: begin
              sclkLvl <= ~sclkLvl;
              if (lastEdge) begin
                edgeCnt <= '0;
                state   <= (cfgLag == '0) ? ST_IDLE : ST_LAG;
              end else begin
                edgeCnt <= edgeCnt + 1'b1;
              end
            end
            ST_LAG: begin
              if (stb.finish) begin
                phaseCnt <= '0;
                state    <= ST_IDLE;
              end else begin
                phaseCnt <= phaseCnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/spi_word_dp.sv
module spi_word_dp
  import spi_word_pkg::*;
#(
  parameter int MAX_W  = 32,
  parameter int WSEL_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  spi_stb_t          stb,
  input  logic [WSEL_W-1:0] effWM1,
  input  logic              lsbFirst,
  input  logic              txEn,
  input  logic              rxEn,
  input  logic              loopback,
  input  logic [MAX_W-1:0]  txWord,
  input  logic              miso,
  output logic              mosi,
  output logic [MAX_W-1:0]  rxWord,
  output logic [CNT_W-1:0]  txByteCount,
  output logic [CNT_W-1:0]  rxByteCount
);

  localparam int NUM_PATH = 2;

  logic [MAX_W-1:0]    txShift;
  logic [MAX_W-1:0]    rxShift;
  logic [MAX_W-1:0]    rxNext;
  logic [MAX_W-1:0]    txSrc;
  logic [MAX_W-1:0]    wordMask;
  logic                mosiReg;
  logic                txBit;
  logic                rxIn;
  logic [CNT_W-1:0]    bytesPerWord;
  logic [NUM_PATH-1:0] pathOn;

  function automatic logic [MAX_W-1:0] maskOf(input logic [WSEL_W-1:0] wm1);
    logic [MAX_W:0] one;
    one = {{MAX_W{1'b0}}, 1'b1} << (int'(wm1) + 1);
    return one[MAX_W-1:0] - 1'b1;
  endfunction

  always_comb begin
    wordMask     = maskOf(effWM1);
    txSrc        = stb.load ? (txWord & wordMask) : txShift;
    txBit        = lsbFirst ? txSrc[0] : txSrc[effWM1];
    mosi         = txEn & mosiReg;
    rxIn         = loopback ? mosi : miso;
    rxNext       = stb.load ? '0 : rxShift;
    if (stb.sample) begin
      rxNext = lsbFirst ? ((rxShift >> 1) | (MAX_W'(rxIn) << effWM1))
                        : ((rxShift << 1) | MAX_W'(rxIn));
    end
    bytesPerWord = CNT_W'(effWM1 >> 3) + CNT_W'(1);
    pathOn       = {rxEn, txEn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      mosiReg <= 1'b0;
      rxWord  <= '0;
    end else begin
      if (stb.launch) begin
        mosiReg <= txBit;
        txShift <= lsbFirst ? (txSrc >> 1) : (txSrc << 1);
      end else if (stb.load) begin
        txShift <= txSrc;
      end
      rxShift <= rxNext;
      if (stb.finish && rxEn) rxWord <= rxNext;
    end
  end

  // one byte counter per path: index 0 transmit, index 1 receive
  for (genvar p = 0; p < NUM_PATH; p++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         cnt <= '0;
      else if (stb.finish && pathOn[p])  cnt <= cnt + bytesPerWord;
    end
  end

  assign txByteCount = g_cnt[0].cnt;
  assign rxByteCount = g_cnt[1].cnt;

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int MAX_W  = 32,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 4,
  parameter int CNT_W  = 16,
  localparam int WSEL_W = $clog2(MAX_W),
  localparam int MIN_WM1 = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WSEL_W-1:0] cfgWidthM1,
  input  logic              cfgLsbFirst,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic              cfgSelActHigh,
  input  logic              cfgSelManual,
  input  logic              cfgSelFwBit,
  input  logic              cfgTxEn,
  input  logic              cfgRxEn,
  input  logic              cfgLoopback,
  input  logic [DLY_W-1:0]  cfgLead,
  input  logic [DLY_W-1:0]  cfgLag,
  input  logic [DIV_W-1:0]  cfgHalfDiv,
  input  logic              start,
  input  logic [MAX_W-1:0]  txWord,
  output logic              busy,
  output logic              done,
  output logic [MAX_W-1:0]  rxWord,
  output logic [CNT_W-1:0]  txByteCount,
  output logic [CNT_W-1:0]  rxByteCount,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ssel
);

  spi_stb_t          stb;
  logic [WSEL_W-1:0] effWM1;
  logic              sclkLvl;
  logic              selOn;

  assign effWM1 = (cfgWidthM1 < WSEL_W'(MIN_WM1)) ? WSEL_W'(MIN_WM1) : cfgWidthM1;

  spi_word_ctrl #(
    .WSEL_W(WSEL_W), .DIV_W(DIV_W), .DLY_W(DLY_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgCpha(cfgCpha),
    .cfgLead(cfgLead), .cfgLag(cfgLag), .cfgHalfDiv(cfgHalfDiv),
    .effWM1(effWM1), .stb(stb), .busy(busy), .done(done), .sclkLvl(sclkLvl)
  );

  spi_word_dp #(
    .MAX_W(MAX_W), .WSEL_W(WSEL_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .effWM1(effWM1),
    .lsbFirst(cfgLsbFirst), .txEn(cfgTxEn), .rxEn(cfgRxEn),
    .loopback(cfgLoopback), .txWord(txWord), .miso(miso), .mosi(mosi),
    .rxWord(rxWord), .txByteCount(txByteCount), .rxByteCount(rxByteCount)
  );

  assign sclk  = sclkLvl ^ cfgCpol;
  assign selOn = cfgSelManual ? cfgSelFwBit : busy;
  assign ssel  = cfgSelActHigh ? selOn : ~selOn;

endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk #(
  parameter int MAX_W = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             cfgCpol,
  input logic             cfgRxEn,
  input logic             cfgSelManual,
  input logic             cfgSelActHigh,
  input logic             busy,
  input logic             done,
  input logic             sclk,
  input logic             ssel,
  input logic [MAX_W-1:0] rxWord,
  input logic [CNT_W-1:0] txByteCount,
  input logic [CNT_W-1:0] rxByteCount
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R1
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rstN) !busy |-> (sclk == cfgCpol)); // R4
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rstN) (!cfgSelManual && !busy) |-> (ssel == !cfgSelActHigh)); // R7
  AST_SEL_BUSY: assert property (@(posedge clk) disable iff (!rstN) (!cfgSelManual && busy) |-> (ssel == cfgSelActHigh)); // R7
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN) !cfgRxEn |=> $stable(rxWord)); // R10
  AST_TXCNT_AT_DONE: assert property (@(posedge clk) disable iff (!rstN) !done |-> $stable(txByteCount)); // R12
  AST_RXCNT_AT_DONE: assert property (@(posedge clk) disable iff (!rstN) !done |-> $stable(rxByteCount)); // R12
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> $past(start)); // R13
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done); // R13

endmodule

bind spi_word_master spi_word_master_chk #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/spi_word_master_tb.sv
module spi_word_master_tb;
  localparam int MAX_W = 32;
  localparam int DIV_W = 8;
  localparam int DLY_W = 4;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]       cfgWidthM1 = 5'd7;
  logic             cfgLsbFirst = 0, cfgCpol = 0, cfgCpha = 0, cfgSelActHigh = 0;
  logic             cfgSelManual = 0, cfgSelFwBit = 0, cfgTxEn = 1, cfgRxEn = 1, cfgLoopback = 0;
  logic [DLY_W-1:0] cfgLead = 4'd1, cfgLag = 4'd1;
  logic [DIV_W-1:0] cfgHalfDiv = 8'd2;
  logic             start = 0;
  logic [MAX_W-1:0] txWord = '0;
  logic             busy, done, sclk, mosi, ssel;
  logic             miso = 1'b0;
  logic [MAX_W-1:0] rxWord;
  logic [CNT_W-1:0] txByteCount, rxByteCount;

  spi_word_master u_dut (
    .clk(clk), .rstN(rstN), .cfgWidthM1(cfgWidthM1), .cfgLsbFirst(cfgLsbFirst),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgSelActHigh(cfgSelActHigh),
    .cfgSelManual(cfgSelManual), .cfgSelFwBit(cfgSelFwBit), .cfgTxEn(cfgTxEn),
    .cfgRxEn(cfgRxEn), .cfgLoopback(cfgLoopback), .cfgLead(cfgLead), .cfgLag(cfgLag),
    .cfgHalfDiv(cfgHalfDiv), .start(start), .txWord(txWord), .busy(busy), .done(done),
    .rxWord(rxWord), .txByteCount(txByteCount), .rxByteCount(rxByteCount),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ssel(ssel)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int effW();
    return (cfgWidthM1 < 5'd3) ? 4 : int'(cfgWidthM1) + 1;
  endfunction

  function automatic logic [31:0] maskW(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  // ---------------- behavioural slave ----------------
  logic        selAct;
  assign selAct = cfgSelActHigh ? ssel : ~ssel;
  logic [31:0] slaveWord = '0;
  logic [31:0] slaveGot = '0;
  int          sIn = 0, sOut = 0;
  logic        sPrevSel = 0, sPrevSclk = 0;

  function automatic int bitPos(input int i);
    return cfgLsbFirst ? i : effW() - 1 - i;
  endfunction

  always @(sclk or selAct) begin
    if (selAct && !sPrevSel) begin
      sIn = 0; sOut = 0; slaveGot = '0;
      if (!cfgCpha) begin miso = slaveWord[bitPos(0)]; sOut = 1; end
    end else if (selAct && (sclk != sPrevSclk)) begin
      if (((sclk != cfgCpol) ? 1'b1 : 1'b0) ^ cfgCpha) begin
        if (sIn < effW()) begin slaveGot[bitPos(sIn)] = mosi; sIn++; end
      end else begin
        if (sOut < effW()) begin miso = slaveWord[bitPos(sOut)]; sOut++; end
      end
    end
    sPrevSel = selAct;
    sPrevSclk = sclk;
  end

  // ---------------- timing / line monitor ----------------
  int   cyc = 0, tSelOn = 0, tFirst = 0, tLast = 0, tSelOff = 0, edges = 0;
  bit   firstSeen = 0, watchMosi = 0, mosiBad = 0, watchSel = 0, selSeen = 0;
  logic mPrevSel = 0, mPrevSclk = 0;
  always @(negedge clk) begin
    cyc++;
    if (selAct && !mPrevSel) begin tSelOn = cyc; edges = 0; firstSeen = 0; end
    if (sclk != mPrevSclk) begin
      edges++;
      if (!firstSeen) begin tFirst = cyc; firstSeen = 1; end
      tLast = cyc;
    end
    if (!selAct && mPrevSel) tSelOff = cyc;
    if (watchMosi && mosi !== 1'b0) mosiBad = 1;
    if (watchSel && selAct) selSeen = 1;
    mPrevSel = selAct;
    mPrevSclk = sclk;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [31:0] rx;
    int          txc;
    int          rxc;
    string       req;
  } item_t;
  item_t sbq[$];
  item_t monItem;
  logic [31:0] expRx = '0;
  int expTxc = 0, expRxc = 0;

  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R13", "done without accepted start", 1, 0);
      end else begin
        monItem = sbq.pop_front();
        chk(rxWord == monItem.rx, monItem.req, "received word", rxWord, monItem.rx);
        chk(int'(txByteCount) == monItem.txc, "R12", "tx byte count", txByteCount, monItem.txc);
        chk(int'(rxByteCount) == monItem.rxc, "R12", "rx byte count", rxByteCount, monItem.rxc);
      end
    end
  end

  task automatic xfer(input logic [31:0] tx, input logic [31:0] sw, input string req,
                      input bit checkSlave);
    int w;
    logic [31:0] m;
    item_t it;
    w = effW();
    m = maskW(w);
    if (cfgRxEn) expRx = cfgLoopback ? (cfgTxEn ? (tx & m) : 32'd0) : (sw & m);
    if (cfgTxEn) expTxc = (expTxc + (w + 7) / 8) % 65536;
    if (cfgRxEn) expRxc = (expRxc + (w + 7) / 8) % 65536;
    it.rx = expRx; it.txc = expTxc; it.rxc = expRxc; it.req = req;
    sbq.push_back(it);
    slaveWord = sw;
    txWord = tx;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done) @(negedge clk);
    if (checkSlave)
      chk(slaveGot == (tx & m), "R3", {"word seen by slave, ", req}, slaveGot, tx & m);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R13", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(rxWord == '0, "R1", "rxWord after reset", rxWord, 0);
    chk(txByteCount == '0 && rxByteCount == '0, "R12", "counts after reset",
        {txByteCount, rxByteCount}, 0);
    chk(sclk == 1'b0, "R4", "sclk idle with cpol 0", sclk, 0);
    chk(ssel == 1'b1, "R6", "active-low select idle", ssel, 1);

    // mode 0, 8 bits, MSB first
    xfer(32'h0000_00A5, 32'h0000_003C, "R5", 1);
    chk(edges == 16, "R4", "sclk transitions for 8 bits", edges, 16);

    // mode 3, LSB first
    cfgCpol = 1; cfgCpha = 1; cfgLsbFirst = 1;
    @(negedge clk);
    chk(sclk == 1'b1, "R4", "sclk idle with cpol 1", sclk, 1);
    xfer(32'h0000_0096, 32'h0000_0061, "R3", 1);

    // 32 bits, mode 2, MSB first
    cfgWidthM1 = 5'd31; cfgCpha = 0; cfgLsbFirst = 0;
    xfer(32'hDEAD_BEEF, 32'h1234_5678, "R2", 1);

    // 13 bits, mode 1, LSB first, high bits masked
    cfgWidthM1 = 5'd12; cfgCpol = 0; cfgCpha = 1; cfgLsbFirst = 1;
    xfer(32'hFFFF_1ABC, 32'hFFFF_0F0F, "R2", 1);

    // width field below minimum acts as 4 bits
    cfgWidthM1 = 5'd1; cfgCpha = 0; cfgLsbFirst = 0;
    xfer(32'h0000_003B, 32'h0000_00F6, "R2", 1);
    chk(edges == 8, "R2", "clamped width transitions", edges, 8);
    chk(rxWord[31:4] == '0, "R1", "upper bits cleared", rxWord[31:4], 0);

    // loopback ignores miso
    cfgWidthM1 = 5'd7; cfgLoopback = 1;
    xfer(32'h0000_003C, 32'h0000_00FF, "R11", 0);
    cfgLoopback = 0;

    // transmit disabled
    cfgTxEn = 0; watchMosi = 1; mosiBad = 0;
    xfer(32'h0000_00FF, 32'h0000_00A7, "R9", 0);
    watchMosi = 0;
    chk(mosiBad == 0, "R9", "mosi stayed low", mosiBad, 0);
    cfgTxEn = 1;

    // receive disabled
    cfgRxEn = 0;
    xfer(32'h0000_0011, 32'h0000_0022, "R10", 1);
    cfgRxEn = 1;

    // lead / lag / divider timing
    cfgHalfDiv = 8'd3; cfgLead = 4'd3; cfgLag = 4'd2;
    xfer(32'h0000_005A, 32'h0000_00C3, "R7", 1);
    @(negedge clk);
    chk(tFirst - tSelOn == 12, "R7", "select to first edge", tFirst - tSelOn, 12);
    chk(tSelOff - tLast == 6, "R7", "last edge to deselect", tSelOff - tLast, 6);
    chk(edges == 16, "R14", "transitions with divider 3", edges, 16);

    cfgHalfDiv = 8'd0; cfgLead = 4'd0; cfgLag = 4'd0;
    xfer(32'h0000_0081, 32'h0000_0018, "R14", 1);
    @(negedge clk);
    chk(tFirst - tSelOn == 1, "R14", "divider 0 acts as 1", tFirst - tSelOn, 1);
    chk(tSelOff == tLast, "R7", "zero lag deselect", tSelOff - tLast, 0);
    cfgHalfDiv = 8'd2; cfgLead = 4'd1; cfgLag = 4'd1;

    // active-high select
    cfgSelActHigh = 1;
    @(negedge clk);
    chk(ssel == 1'b0, "R6", "active-high select idle", ssel, 0);
    xfer(32'h0000_00E1, 32'h0000_004D, "R6", 1);

    // firmware-controlled select
    cfgSelManual = 1; cfgSelFwBit = 0; cfgLoopback = 1; watchSel = 1; selSeen = 0;
    xfer(32'h0000_0077, 32'h0000_0000, "R8", 0);
    watchSel = 0;
    chk(selSeen == 0, "R8", "select held inactive", selSeen, 0);
    cfgLoopback = 0;
    cfgSelFwBit = 1;
    @(negedge clk);
    chk(ssel == 1'b1, "R8", "select follows firmware bit", ssel, 1);
    xfer(32'h0000_00B4, 32'h0000_0039, "R8", 1);
    repeat (3) @(negedge clk);
    chk(ssel == 1'b1, "R8", "select stays after word", ssel, 1);
    cfgSelFwBit = 0; cfgSelManual = 0; cfgSelActHigh = 0;

    // start ignored while busy
    fork
      xfer(32'h0000_00C3, 32'h0000_005A, "R13", 1);
      begin
        repeat (10) @(negedge clk);
        txWord = 32'h0000_00FF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R13", "busy kept through extra start", busy, 1);
      end
    join
    repeat (60) @(negedge clk);
    chk(sbq.size() == 0, "R13", "no pending words", sbq.size(), 0);
    chk(busy == 1'b0, "R13", "idle after word", busy, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule